// File: doc/BRIEF.md
# Two-Wire Serial Register Bank Slave

This block is a slave on a two-wire serial bus (clock and open-drain data). Through it, a bus master reads and writes a bank of 47 eight-bit control registers at addresses 0x00 through 0x2E. A faster system clock samples both bus lines. The block finds start, repeated start and stop conditions in the sampled values and shifts bytes in and out with the most significant bit first.

A write transaction has three parts: the device address, one byte that loads the register pointer, and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then moves up by one until it reaches the top register. A read transaction starts at the pointer left by the previous transaction. The usual way to start a read is to send the pointer in a write and then issue a repeated start with the read direction. The low bit of the device address comes from a strap input, so two of these blocks can share one bus. A parallel port lets the surrounding logic read every register at any time.

Top module: `tws_regbank_slave`

## Requirements
- R1: After reset every register reads 0x00, the pointer is 0x00 and `sda_oe` is low.
- R2: The device address is the 7-bit value 100110s, where s is `addr_sel`. The bit after the address selects the direction: 0 means the master writes and 1 means the master reads. When the address matches, the slave drives SDA low during the ninth SCL pulse.
- R3: When the address does not match, SDA stays released for the rest of the transaction. No register changes and nothing is acknowledged until the next start.
- R4: In a write, the first byte after the address loads the pointer. Each later byte is stored at the pointer and is acknowledged, and the pointer then increases by one. All bytes are sent MSB first.
- R5: The pointer never goes above 0x2E. Once it reaches 0x2E, later data bytes in a write keep overwriting register 0x2E, and later bytes in a read keep returning register 0x2E.
- R6: A pointer byte above 0x2E gets no acknowledge. The pointer keeps its old value, and no data byte after it is stored or acknowledged.
- R7: A read returns the register at the current pointer, MSB first. The pointer increases by one after each byte, up to the limit in R5. The pointer carries over from earlier transactions.
- R8: If the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next start or stop.
- R9: A repeated start begins a new address phase and keeps the pointer. This lets a read follow a pointer write without a stop in between.
- R10: A stop returns the slave to idle, and `sda_oe` goes low.
- R11: Apart from start and stop handling, `sda_oe` changes only while SCL is low.
- R12: `rd_data` shows the register at `rd_addr` one clock after `rd_addr` is applied. It shows 0x00 when `rd_addr` is above 0x2E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Strap input that sets the low bit of the device address |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pin pulls SDA low (open drain) |
| rd_addr | input | 6 | Register index for the parallel read port |
| rd_data | output | 8 | Register contents for the parallel read port |

## Verification
Two functions can fall on the same bus clock: the last write before the pointer limit, and the saturation of the pointer. The write to 0x2E and the decision that the pointer stays at 0x2E are made on the same SCL falling edge. The bench provokes this by setting the pointer to 0x2C or 0x2D and then sending more bytes than the registers left above it. It judges the result through the parallel port: the lower registers must hold the early bytes, and 0x2E must hold the last byte. The same pair appears on the read side, where the byte sent from 0x2E and the held pointer must give the same value again on the next byte. Randomly chosen pointers and transaction lengths make both collisions occur often, and a reference model in the bench checks every result.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_TX, ST_TXEND, ST_TXNEXT, ST_WAIT
  } st_t;

  typedef enum logic [1:0] {
    K_ADDR, K_PTR, K_DATA
  } kind_t;
endpackage

// File: rtl/tws_rst_sync.sv
module tws_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-1:0], din[g]};
    end
    assign cur[g]  = pipe_q[STAGES-1];
    assign prev[g] = pipe_q[STAGES];
  end
endmodule

// File: rtl/tws_regs.sv
module tws_regs #(
  parameter int unsigned NREG = 47,
  localparam int unsigned PW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [PW-1:0] tx_addr,
  output logic [7:0]    tx_data,
  input  logic [PW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wr_data;
    end
  end

  assign tx_data = (tx_addr < PW'(NREG)) ? mem_q[tx_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= (rd_addr < PW'(NREG)) ? mem_q[rd_addr] : '0;
  end
endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
  import tws_pkg::*;
#(
  parameter int unsigned NREG   = 47,
  parameter logic [5:0]  DEV_HI = 6'b100110,
  localparam int unsigned PW    = $clog2(NREG),
  localparam logic [7:0]  MAXB  = 8'(NREG - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          scl_s,
  input  logic          scl_p,
  input  logic          sda_s,
  input  logic          sda_p,
  input  logic [7:0]    tx_byte,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic [PW-1:0] ptr,
  output logic          ptr_load,
  output logic          sda_oe,
  output st_t           st,
  output logic          start_det,
  output logic          stop_det
);
  st_t           st_q, st_d;
  kind_t         kind_q, kind_d;
  logic [2:0]    bcnt_q, bcnt_d;
  logic [7:0]    sh_q, sh_d;
  logic          rw_q, rw_d;
  logic [PW-1:0] ptr_q, ptr_d, ptr_inc;
  logic          oe_q, oe_d;
  logic          scl_rise, scl_fall;

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign ptr_inc   = (ptr_q == PW'(NREG - 1)) ? ptr_q : ptr_q + 1'b1;

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    bcnt_d   = bcnt_q;
    sh_d     = sh_q;
    rw_d     = rw_q;
    ptr_d    = ptr_q;
    oe_d     = oe_q;
    wr_en    = 1'b0;
    ptr_load = 1'b0;
    if (start_det) begin
      st_d   = ST_RX;
      kind_d = K_ADDR;
      bcnt_d = '0;
      oe_d   = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: if (scl_rise) begin
          sh_d = {sh_q[6:0], sda_s};
          if (bcnt_q == 3'd7) st_d = ST_RXEND;
          else                bcnt_d = bcnt_q + 1'b1;
        end
        ST_RXEND: if (scl_fall) begin
          unique case (kind_q)
            K_ADDR: begin
              if (sh_q[7:1] == {DEV_HI, addr_sel}) begin
                rw_d = sh_q[0];
                oe_d = 1'b1;
                st_d = ST_ACK;
              end else begin
                st_d = ST_WAIT;
              end
            end
            K_PTR: begin
              if (sh_q <= MAXB) begin
                ptr_d    = sh_q[PW-1:0];
                ptr_load = 1'b1;
                oe_d     = 1'b1;
                st_d     = ST_ACK;
              end else begin
                st_d = ST_WAIT;
              end
            end
            default: begin
              wr_en = 1'b1;
              ptr_d = ptr_inc;
              oe_d  = 1'b1;
              st_d  = ST_ACK;
            end
          endcase
        end
        ST_ACK: if (scl_fall) begin
          bcnt_d = '0;
          if (kind_q == K_ADDR && rw_q) begin
            st_d = ST_TX;
            sh_d = tx_byte;
            oe_d = ~tx_byte[7];
          end else begin
            oe_d   = 1'b0;
            st_d   = ST_RX;
            kind_d = (kind_q == K_ADDR) ? K_PTR : K_DATA;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bcnt_q == 3'd7) begin
            oe_d  = 1'b0;
            ptr_d = ptr_inc;
            st_d  = ST_TXEND;
          end else begin
            sh_d   = {sh_q[6:0], 1'b0};
            oe_d   = ~sh_q[6];
            bcnt_d = bcnt_q + 1'b1;
          end
        end
        ST_TXEND: if (scl_rise) begin
          st_d = sda_s ? ST_WAIT : ST_TXNEXT;
        end
        ST_TXNEXT: if (scl_fall) begin
          st_d   = ST_TX;
          sh_d   = tx_byte;
          oe_d   = ~tx_byte[7];
          bcnt_d = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_ADDR;
      bcnt_q <= '0;
      sh_q   <= '0;
      rw_q   <= 1'b0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      rw_q   <= rw_d;
      ptr_q  <= ptr_d;
      oe_q   <= oe_d;
    end
  end

  assign wr_data = sh_q;
  assign ptr     = ptr_q;
  assign sda_oe  = oe_q;
  assign st      = st_q;
endmodule

// File: rtl/tws_regbank_slave.sv
module tws_regbank_slave
  import tws_pkg::*;
#(
  parameter int unsigned NREG        = 47,
  parameter logic [5:0]  DEV_HI      = 6'b100110,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PW         = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [PW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic          rst_n_i;
  logic [1:0]    line_cur, line_prev;
  logic          scl_s, scl_p, sda_s, sda_p;
  logic          wr_en, ptr_load, start_det, stop_det;
  logic [7:0]    wr_data, tx_byte;
  logic [PW-1:0] ptr;
  st_t           st;

  tws_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  tws_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .din({scl_in, sda_in}),
    .cur(line_cur), .prev(line_prev)
  );

  assign scl_s = line_cur[1];
  assign sda_s = line_cur[0];
  assign scl_p = line_prev[1];
  assign sda_p = line_prev[0];

  tws_fsm #(.NREG(NREG), .DEV_HI(DEV_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n_i), .addr_sel(addr_sel),
    .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
    .tx_byte(tx_byte), .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr),
    .ptr_load(ptr_load), .sda_oe(sda_oe), .st(st),
    .start_det(start_det), .stop_det(stop_det)
  );

  tws_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr_en(wr_en), .wr_addr(ptr),
    .wr_data(wr_data), .tx_addr(ptr), .tx_data(tx_byte),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/tws_regbank_chk.sv
module tws_regbank_chk
  import tws_pkg::*;
#(
  parameter int unsigned NREG = 47,
  localparam int unsigned PW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_oe,
  input logic          ptr_load,
  input logic [PW-1:0] ptr,
  input st_t           st
);
  AST_PTR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(NREG - 1)); // R5

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) && !$past(ptr_load) |-> ptr == PW'($past(ptr) + 1'b1)); // R4

  AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && st == ST_IDLE)); // R10

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det) |-> !scl_s); // R11

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_WAIT |-> !sda_oe); // R3

  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> st == ST_RX); // R9
endmodule

bind tws_regbank_slave tws_regbank_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .ptr_load(ptr_load),
  .ptr(ptr), .st(st)
);

// File: tb/sim_tws_regbank_slave.sv
`timescale 1ns/1ps
module sim_tws_regbank_slave;
  localparam int NREG = 47;
  localparam int Q    = 8;

  logic       clk = 1'b0;
  logic       rst_n, addr_sel, scl, m_sda;
  logic [5:0] rd_addr;
  logic [7:0] rd_data;
  logic       sda_oe;
  wire        sda_bus = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int r11_viol = 0;
  logic [7:0] ref_mem [NREG];
  int ref_ptr;

  always #4 clk = ~clk;

  tws_regbank_slave u0 (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_in(scl),
    .sda_in(sda_bus), .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R11 monitor: sda_oe must not move while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && sda_oe !== oe_prev && scl === 1'b1) r11_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int sat_inc(input int p);
    return (p == NREG - 1) ? p : p + 1;
  endfunction

  function automatic logic [7:0] dev_byte(input logic sel, input logic rd);
    return {6'b100110, sel, rd};
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; w(Q); scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(Q); scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    end
    m_sda = 1'b1; w(Q); scl = 1'b1; w(Q);
    acked = (sda_bus == 1'b0);
    w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1'b1; w(Q); b[i] = sda_bus; w(Q); scl = 1'b0; w(Q);
    end
    m_sda = nack; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    m_sda = 1'b1;
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < NREG; a++) begin
      rd_addr = 6'(a); w(2);
      chk(rd_data == ref_mem[a], req, rd_data, ref_mem[a]);
    end
  endtask

  // write transaction: address, pointer byte, n data bytes
  task automatic wr_txn(input logic [7:0] p, input int n, input bit stop);
    bit ack, okp;
    logic [7:0] b;
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b0), ack);
    chk(ack, "R2 addr ack", ack, 1);
    send_byte(p, ack);
    okp = (p <= 8'(NREG - 1));
    chk(ack == okp, "R6/R4 ptr ack", ack, okp);
    if (okp) ref_ptr = p;
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      send_byte(b, ack);
      chk(ack == okp, "R4/R6 data ack", ack, okp);
      if (okp) begin ref_mem[ref_ptr] = b; ref_ptr = sat_inc(ref_ptr); end
    end
    if (stop) bus_stop();
  endtask

  // read transaction from current pointer, n bytes, last one NACKed
  task automatic rd_txn(input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b1), ack);
    chk(ack, "R2 read addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      chk(b == ref_mem[ref_ptr], req, b, ref_mem[ref_ptr]);
      ref_ptr = sat_inc(ref_ptr);
    end
    w(4*Q);
    chk(sda_oe == 1'b0, "R8 release after NACK", sda_oe, 0);
    bus_stop();
    w(4);
    chk(sda_oe == 1'b0, "R10 idle after stop", sda_oe, 0);
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; addr_sel = 1'b0; scl = 1'b1; m_sda = 1'b1; rd_addr = '0;
    for (int a = 0; a < NREG; a++) ref_mem[a] = '0;
    ref_ptr = 0;
    w(5); rst_n = 1'b1; w(5);

    chk(sda_oe == 1'b0, "R1 oe reset", sda_oe, 0);
    check_all("R1 reset regs");
    rd_addr = 6'd50; w(2);
    chk(rd_data == 8'h00, "R12 out of range read", rd_data, 0);
    rd_txn(1, "R1 reset ptr read");

    // R4 basic write, check via parallel port
    wr_txn(8'h03, 4, 1'b1);
    check_all("R4 write burst");
    w(4);
    chk(sda_oe == 1'b0, "R10 oe after stop", sda_oe, 0);

    // R3 wrong address
    bus_start();
    send_byte(dev_byte(1'b1, 1'b0), ack);
    chk(!ack, "R3 mismatch nack", ack, 0);
    send_byte(8'h05, ack);
    chk(!ack, "R3 ignored ptr", ack, 0);
    send_byte(8'hA5, ack);
    chk(!ack, "R3 ignored data", ack, 0);
    bus_stop();
    check_all("R3 no change");
    rd_txn(1, "R3 ptr kept");

    // R2 address select high
    addr_sel = 1'b1; w(4);
    wr_txn(8'h10, 2, 1'b1);
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), ack);
    chk(!ack, "R2 old address rejected", ack, 0);
    bus_stop();

    // R5 saturation on write
    wr_txn(8'h2C, 5, 1'b1);
    check_all("R5 saturated write");
    // R5 saturation on read: pointer sits at 0x2E
    rd_txn(3, "R5 saturated read");

    // R6 out-of-range pointer
    wr_txn(8'h2F, 2, 1'b1);
    wr_txn(8'hFF, 1, 1'b1);
    check_all("R6 nothing stored");
    rd_txn(1, "R6 ptr unchanged");

    // R9 pointer write then repeated start then read
    wr_txn(8'h02, 0, 1'b0);
    rd_txn(4, "R9 R7 repeated start read");
    // R7 read continues from earlier transaction pointer
    wr_txn(8'h2A, 2, 1'b1);
    rd_txn(3, "R7 continue read");

    // random mix
    for (int t = 0; t < 14; t++) begin
      if ($urandom_range(0, 1) == 0)
        wr_txn(8'($urandom_range(0, 48)), int'($urandom_range(1, 4)), 1'($urandom_range(0, 1)));
      else begin
        if ($urandom_range(0, 1) == 0) wr_txn(8'($urandom_range(0, 46)), 0, 1'b0);
        rd_txn(int'($urandom_range(1, 4)), "R7 random read");
      end
    end
    check_all("R4 R12 final contents");

    chk(r11_viol == 0, "R11 oe moved with SCL high", r11_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule